// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache that sits between a processor and a slower memory. The cache splits each byte address into three fields. The high bits form the tag. The middle bits pick one line. The low bits pick the word inside the block and the byte inside the word. Each line holds a valid flag, a tag and a block of several words.

A read that finds its block answers from the line. A read that misses first waits until the write buffer has drained. It then fetches the whole block through a block-read port, installs the block and answers with the addressed word.

Every store is write-through. The store enters a small in-order buffer, and the buffer feeds a single-word memory write port. A store that hits also updates the lanes selected by its byte enables in the line. A store that misses leaves the cache unchanged, so there is no allocation on a write miss.

All data-carrying interfaces use valid/ready:

- A transfer happens on a rising edge where valid and ready are both high.
- A sender keeps valid and its payload unchanged until that edge.
- The cache lowers `req_ready` while a miss is in flight.
- The cache also lowers `req_ready` while a store meets a full buffer, and it raises the plain `stall` pin for that case.

Top module: `wt_cache`

## Requirements
- R1: The byte address splits as follows: byte-in-word = low log2(DATA_W/8) bits, word-in-block = next log2(WORDS) bits, line index = next log2(LINES) bits (block address modulo LINES), tag = all remaining upper bits. A lookup hits only when the indexed line is valid and its stored tag equals the address tag.
- R2: After reset no line is valid, `req_ready` is high, and `rsp_valid`, `stall`, `mem_rd_valid` and `mem_wr_valid` are low. The first read of any block misses.
- R3: A read that hits is accepted in the IDLE state, and `rsp_valid` is high for exactly the next cycle with `rsp_hit`=1. `rsp_rdata` holds the addressed word, and no block read is issued.
- R4: A read that misses raises `mem_rd_valid` with `mem_rd_addr` equal to the request address with its offset bits cleared, and it holds them until `mem_rd_ready`. In the cycle `mem_rd_rsp_valid` is high, the cache stores `mem_rd_block` (word k at bits k*DATA_W), writes the tag and sets the valid flag. It then responds in the following cycle with `rsp_hit`=0 and the addressed word. A later read of that block hits.
- R5: Two blocks with the same index evict each other. With eight lines, the block-address sequence 22, 26, 22, 26, 16, 3, 16, 18 gives miss, miss, hit, hit, miss, miss, hit, miss.
- R6: Every accepted store appears once on the memory write port, in acceptance order, with its address, data and byte enables. `mem_wr_valid` and the payload stay stable until `mem_wr_ready`.
- R7: The buffer holds WB_DEPTH stores. While it is full, a presented store sees `stall`=1 and `req_ready`=0. The store is accepted after an entry drains.
- R8: A store that hits replaces only the byte lanes whose `req_be` bit is 1 (bit b covers data bits 8b+7..8b) in the addressed word of the line. The other lanes keep their values.
- R9: A store that misses issues no block read and changes no line, so a later read of the stored block still misses.
- R10: After a read miss is accepted, `mem_rd_valid` stays low until the write buffer is empty, so the fetched block already holds every earlier store.
- R11: A store is answered with `rsp_valid` high in the cycle after acceptance. Its `rsp_hit` tells whether the line held the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache accepts the request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Load data |
| rsp_hit | output | 1 | Request found its block in the cache |
| stall | output | 1 | Store held off by a full write buffer |
| mem_rd_valid | output | 1 | Block read request valid |
| mem_rd_ready | input | 1 | Memory accepts the block read |
| mem_rd_addr | output | ADDR_W | Block-aligned read address |
| mem_rd_rsp_valid | input | 1 | Block data valid |
| mem_rd_block | input | WORDS*DATA_W | Returned block |
| mem_wr_valid | output | 1 | Buffered store valid |
| mem_wr_ready | input | 1 | Memory accepts the store |
| mem_wr_addr | output | ADDR_W | Store byte address |
| mem_wr_data | output | DATA_W | Store data |
| mem_wr_be | output | DATA_W/8 | Store byte enables |

## Verification
The assertions rely on two input rules:

- The requester keeps each request stable while it waits for `req_ready`.
- The memory returns exactly one `mem_rd_rsp_valid` pulse for each accepted block read, and never one when no read is outstanding.

The bench follows both rules. It changes request inputs only on falling edges and holds them until it has seen `req_ready`. Its memory model answers each read handshake it sees with one block after a fixed delay.

The bench holds `mem_wr_ready` low on purpose to fill the buffer and to keep a read miss waiting. This is the only back-pressure applied; `mem_rd_ready` is always high.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    WTC_IDLE  = 2'd0,
    WTC_FETCH = 2'd1,
    WTC_FILL  = 2'd2
  } wtc_state_e;

  function automatic int unsigned wtc_ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/wtc_tags.sv
module wtc_tags #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

  // R4: a fill leaves the line valid with the fetched tag
  assert_fill_installs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
  parameter int LINES  = 64,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int WSEL_W = 2
) (
  input  logic                      clk,
  input  logic [IDX_W-1:0]          look_idx,
  input  logic [WSEL_W-1:0]         look_word,
  output logic [DATA_W-1:0]         look_data,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [DATA_W/8-1:0]       wr_be,
  input  logic                      fill_en,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic [WORDS*DATA_W-1:0]   fill_block
);

  localparam int BYTES = DATA_W / 8;
  localparam int BLK_W = WORDS * DATA_W;

  logic [BLK_W-1:0]  lines_q [LINES];
  logic [DATA_W-1:0] merged;

  assign look_data = lines_q[look_idx][int'(look_word)*DATA_W +: DATA_W];

  // byte-lane merge of the store into the current word
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : look_data[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (fill_en)
      lines_q[fill_idx] <= fill_block;
    else if (wr_en)
      lines_q[look_idx][int'(look_word)*DATA_W +: DATA_W] <= merged;
  end

  // R8: a store hit and a fill never share a cycle
  assert_store_fill_apart_R8: assert property (@(posedge clk)
    !(fill_en && wr_en));

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         empty,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int PTR_W = wtc_pkg::wtc_ptr_w(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign out_valid = !empty;
  assign out_data  = slot_q[rd_ptr_q];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= next_ptr(wr_ptr_q);
      if (pop)  rd_ptr_q <= next_ptr(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic look_hit,
  input  logic wb_full,
  input  logic wb_empty,
  input  logic mem_rd_ready,
  input  logic mem_rd_rsp_valid,
  output logic req_ready,
  output logic stall,
  output logic wb_push,
  output logic line_write,
  output logic miss_latch,
  output logic rd_hit_load,
  output logic mem_rd_valid,
  output logic fill_en,
  output logic rsp_valid,
  output logic rsp_hit
);

  wtc_state_e state_q, state_d;
  logic       take;

  assign req_ready    = (state_q == WTC_IDLE) && !(req_write && wb_full);
  assign stall        = req_valid && req_write && wb_full;
  assign take         = req_valid && req_ready;
  assign wb_push      = take && req_write;
  assign line_write   = wb_push && look_hit;
  assign rd_hit_load  = take && !req_write && look_hit;
  assign miss_latch   = take && !req_write && !look_hit;
  assign mem_rd_valid = (state_q == WTC_FETCH) && wb_empty;
  assign fill_en      = (state_q == WTC_FILL) && mem_rd_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WTC_IDLE:  if (miss_latch) state_d = WTC_FETCH;
      WTC_FETCH: if (mem_rd_valid && mem_rd_ready) state_d = WTC_FILL;
      WTC_FILL:  if (fill_en) state_d = WTC_IDLE;
      default:   state_d = WTC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WTC_IDLE;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= wb_push || rd_hit_load || fill_en;
      rsp_hit   <= line_write || rd_hit_load;
    end
  end

  assert_hit_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_load |=> rsp_valid && rsp_hit);

  assert_store_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |=> rsp_valid && (rsp_hit == $past(look_hit)));

  assert_rd_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid);

  assert_fill_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> rsp_valid && !rsp_hit && req_ready == !(req_write && wb_full));

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LINES    = 64,
  parameter int WORDS    = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_be,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_hit,
  output logic                     stall,
  output logic                     mem_rd_valid,
  input  logic                     mem_rd_ready,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic                     mem_rd_rsp_valid,
  input  logic [WORDS*DATA_W-1:0]  mem_rd_block,
  output logic                     mem_wr_valid,
  input  logic                     mem_wr_ready,
  output logic [ADDR_W-1:0]        mem_wr_addr,
  output logic [DATA_W-1:0]        mem_wr_data,
  output logic [DATA_W/8-1:0]      mem_wr_be
);

  localparam int BYTES  = DATA_W / 8;
  localparam int BSEL_W = $clog2(BYTES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BSEL_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int ENT_W  = ADDR_W + DATA_W + BYTES;
  localparam int HI_W   = ADDR_W - BSEL_W;

  logic [IDX_W-1:0]  look_idx, fill_idx;
  logic [TAG_W-1:0]  look_tag, fill_tag;
  logic [WSEL_W-1:0] look_word, fill_word;
  logic [DATA_W-1:0] look_data, rdata_q;
  logic [HI_W-1:0]   miss_q;
  logic              look_hit, wb_full, wb_empty, wb_push, line_write;
  logic              miss_latch, rd_hit_load, fill_en;
  logic [ENT_W-1:0]  wb_out;

  assign look_idx  = req_addr[OFF_W +: IDX_W];
  assign look_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign look_word = req_addr[BSEL_W +: WSEL_W];

  assign fill_idx  = miss_q[WSEL_W +: IDX_W];
  assign fill_tag  = miss_q[HI_W-1 -: TAG_W];
  assign fill_word = miss_q[WSEL_W-1:0];

  assign mem_rd_addr = {miss_q[HI_W-1:WSEL_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= '0;
    else if (miss_latch) miss_q <= req_addr[ADDR_W-1:BSEL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_hit_load) rdata_q <= look_data;
    else if (fill_en) rdata_q <= mem_rd_block[int'(fill_word)*DATA_W +: DATA_W];
  end
  assign rsp_rdata = rdata_q;

  wtc_ctrl u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .look_hit         (look_hit),
    .wb_full          (wb_full),
    .wb_empty         (wb_empty),
    .mem_rd_ready     (mem_rd_ready),
    .mem_rd_rsp_valid (mem_rd_rsp_valid),
    .req_ready        (req_ready),
    .stall            (stall),
    .wb_push          (wb_push),
    .line_write       (line_write),
    .miss_latch       (miss_latch),
    .rd_hit_load      (rd_hit_load),
    .mem_rd_valid     (mem_rd_valid),
    .fill_en          (fill_en),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit)
  );

  wtc_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_idx (look_idx),
    .look_tag (look_tag),
    .look_hit (look_hit),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_tag (fill_tag)
  );

  wtc_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
    .clk        (clk),
    .look_idx   (look_idx),
    .look_word  (look_word),
    .look_data  (look_data),
    .wr_en      (line_write),
    .wr_data    (req_wdata),
    .wr_be      (req_be),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_block (mem_rd_block)
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wb_push),
    .push_data ({req_addr, req_wdata, req_be}),
    .full      (wb_full),
    .empty     (wb_empty),
    .out_valid (mem_wr_valid),
    .out_ready (mem_wr_ready),
    .out_data  (wb_out)
  );

  assign {mem_wr_addr, mem_wr_data, mem_wr_be} = wb_out;

  assert_fetch_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !mem_wr_valid);

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);

  assert_rd_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr));

  assert_store_no_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !mem_rd_valid);

endmodule

// File: tb/wt_cache_bench.sv
module wt_cache_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, rsp_hit, stall;
  logic [31:0] rsp_rdata;
  logic        mem_rd_valid, mem_rd_ready, mem_rd_rsp_valid = 1'b0;
  logic [31:0] mem_rd_addr;
  logic [63:0] mem_rd_block = '0;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;
  logic        wr_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rd_ready = 1'b1;
  assign mem_wr_ready = !wr_hold;

  wt_cache #(.ADDR_W(32), .DATA_W(32), .LINES(8), .WORDS(2), .WB_DEPTH(4)) u_wt_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit), .stall(stall),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_block(mem_rd_block),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  int checks = 0, errors = 0;
  logic [31:0] bmem [1024];
  logic [31:0] ref_mem [1024];
  logic        bv [8];
  logic [25:0] bt [8];
  logic [31:0] q_addr[$], q_data[$];
  logic [3:0]  q_be[$];
  int          rd_reqs = 0, rd_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic        cur_wr, exp_hit_g, last_hit_g;
  logic [31:0] cur_addr;
  int          rd_before_g;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: block reads after a fixed delay, store drain with order check
  always @(negedge clk) begin
    #1;
    mem_rd_rsp_valid = 1'b0;
    if (rd_cnt == 1) begin
      mem_rd_rsp_valid = 1'b1;
      for (int k = 0; k < 2; k++) mem_rd_block[k*32 +: 32] = bmem[(last_rd_addr >> 2) + k];
    end
    if (rd_cnt > 0) rd_cnt--;
    else if (mem_rd_valid) begin
      last_rd_addr = mem_rd_addr;
      rd_reqs++;
      rd_cnt = 3;
    end
    if (mem_rd_valid && mem_wr_valid) begin
      errors++;
      $display("FAIL R10 actual=fetch-with-pending-store expected=none");
    end
    if (mem_wr_valid && mem_wr_ready) begin
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) bmem[mem_wr_addr[11:2]][b*8 +: 8] = mem_wr_data[b*8 +: 8];
      if (q_addr.size() == 0) chk("R6 unexpected store", 1, 0);
      else begin
        chk("R6 store order", {mem_wr_addr, mem_wr_data}, {q_addr[0], q_data[0]});
        chk("R6 store be", 64'(mem_wr_be), 64'(q_be[0]));
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_be.pop_front());
      end
    end
  end

  task automatic drive(input logic wr, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    cur_wr = wr; cur_addr = a;
  endtask

  task automatic accept_req();
    int n = 0;
    int idx;
    #1;
    while (!req_ready && n < 2000) begin @(negedge clk); #1; n++; end
    idx = int'(cur_addr[5:3]);
    exp_hit_g = bv[idx] && (bt[idx] == cur_addr[31:6]);
    rd_before_g = rd_reqs;
    if (cur_wr) begin
      for (int b = 0; b < 4; b++)
        if (req_be[b]) ref_mem[cur_addr[11:2]][b*8 +: 8] = req_wdata[b*8 +: 8];
      q_addr.push_back(cur_addr); q_data.push_back(req_wdata); q_be.push_back(req_be);
    end else if (!exp_hit_g) begin
      bv[idx] = 1'b1; bt[idx] = cur_addr[31:6];
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input string tag);
    int n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk({tag, " R1 hit flag"}, 64'(rsp_hit), 64'(exp_hit_g));
    last_hit_g = rsp_hit;
    if (cur_wr) begin
      chk("R11 store answer delay", 64'(n), 0);
      chk("R9 store issues no fetch", 64'(rd_reqs), 64'(rd_before_g));
    end else begin
      chk({tag, " load data"}, 64'(rsp_rdata), 64'(ref_mem[cur_addr[11:2]]));
      if (exp_hit_g) chk("R3 hit answer delay", 64'(n), 0);
      else begin
        chk("R4 one block read", 64'(rd_reqs), 64'(rd_before_g + 1));
        chk("R4 block address", 64'(last_rd_addr), 64'({cur_addr[31:3], 3'b000}));
      end
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string tag);
    drive(wr, a, d, be);
    accept_req();
    respond(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seq_b [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
    logic seq_h [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    for (int i = 0; i < 1024; i++) begin
      bmem[i] = 32'h3C00_0000 ^ (32'(i) * 32'h0101_0107);
      ref_mem[i] = bmem[i];
    end
    for (int i = 0; i < 8; i++) begin bv[i] = 1'b0; bt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 req_ready", 64'(req_ready), 1);
    chk("R2 idle outputs", 64'({rsp_valid, stall, mem_rd_valid, mem_wr_valid}), 0);

    // R5 conflict sequence, block address b -> byte address b*8
    for (int i = 0; i < 8; i++) begin
      access(1'b0, 32'(seq_b[i] * 8), '0, '0, "R5");
      chk("R5 sequence outcome", 64'(last_hit_g), 64'(seq_h[i]));
    end

    // R1/R3/R4 sweep: two tags per index evict each other
    for (int t = 4; t < 6; t++)
      for (int ix = 0; ix < 8; ix++)
        for (int w = 0; w < 2; w++)
          access(1'b0, 32'(t * 64 + ix * 8 + w * 4), '0, '0, "R4");
    for (int ix = 0; ix < 8; ix++)
      access(1'b0, 32'(4 * 64 + ix * 8 + 4), '0, '0, "R1");

    // R8 every byte-enable pattern on a resident word, read back each time
    access(1'b0, 32'(5 * 64 + 2 * 8), '0, '0, "R3");
    for (int be = 0; be < 16; be++) begin
      access(1'b1, 32'(5 * 64 + 2 * 8), 32'hF0E0_0000 | (32'(be) * 32'h0000_1111), 4'(be), "R8");
      access(1'b0, 32'(5 * 64 + 2 * 8), '0, '0, "R8");
    end

    // R9 store miss leaves the cache unchanged
    access(1'b0, 32'(5 * 64 + 3 * 8), '0, '0, "R9");
    access(1'b1, 32'(9 * 64 + 3 * 8), 32'h1234_5678, 4'hF, "R9");
    access(1'b0, 32'(5 * 64 + 3 * 8), '0, '0, "R9");
    access(1'b0, 32'(9 * 64 + 3 * 8), '0, '0, "R9");

    // R7 buffer saturation
    repeat (8) @(negedge clk);
    wr_hold = 1'b1;
    for (int i = 0; i < 4; i++)
      access(1'b1, 32'(9 * 64 + 3 * 8 + (i % 2) * 4), 32'hAB00_0000 + 32'(i), 4'hF, "R7");
    drive(1'b1, 32'(9 * 64 + 3 * 8), 32'hCAFE_0005, 4'h3);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R7 stall raised", 64'({stall, req_ready}), 64'(2'b10));
      @(negedge clk);
    end
    wr_hold = 1'b0;
    accept_req();
    respond("R7");
    access(1'b0, 32'(9 * 64 + 3 * 8), '0, '0, "R7");

    // R10 read miss waits for pending stores to the same block
    repeat (8) @(negedge clk);
    wr_hold = 1'b1;
    access(1'b1, 32'(10 * 64 + 4 * 8), 32'h5A5A_0001, 4'hF, "R10");
    access(1'b1, 32'(10 * 64 + 4 * 8 + 4), 32'h5A5A_0002, 4'hF, "R10");
    drive(1'b0, 32'(10 * 64 + 4 * 8), '0, '0);
    accept_req();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk("R10 fetch held", 64'(mem_rd_valid), 0);
    end
    @(negedge clk);
    wr_hold = 1'b0;
    respond("R10");
    access(1'b0, 32'(10 * 64 + 4 * 8 + 4), '0, '0, "R10");

    repeat (10) @(negedge clk);
    chk("R6 all stores drained", 64'(q_addr.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule